// File: doc/BRIEF.md
# Masked Chip Select Address Decoder

This block turns the upper sixteen bits of a 32-bit bus address into seven chip-select lines. Each line has its own window, set by a 16-bit base and a 16-bit mask. A mask bit of 1 makes the matching address bit a don't-care, so one window can cover 2^(16+k) bytes, where k is the number of mask bits that are set.

A hit is then qualified by the type of access. Writes can be refused per window. The access class can be refused per window: supervisor or user, code or data, and CPU-space cycles. Accesses from a DMA master can be set to skip the supervisor/user and code/data checks. A valid bit enables each window.

Configuration goes through a simple word-wide write port with a combinational read-back. During an access, the block registers a one-hot chip-select vector on the clock edge while the address strobe is high. If more than one window matches, the lowest-numbered one is chosen. The vector returns to zero on the edge after the strobe drops.

Top module: `cs_decoder`

## Requirements
- R1: After reset every register reads zero and cs_o is zero. All windows are therefore disabled.
- R2: Window n has two registers. Its base register is at offset 0x80+12n and holds the base in bits 15:0. Its mask register is at offset 0x84+12n and holds the address mask in bits 31:16, write-protect at bit 8, DMA-class-enable at bit 6, and five class blocks at bits 5 to 1: CPU-space, supervisor code, supervisor data, user code, user data. The valid bit is at bit 0. Unused bits read zero. Other offsets read zero and writes to them change nothing.
- R3: A window matches when addr_i[31:16] equals the base in every bit position where the mask bit is 0. For example, base 0x0000 with mask 0x0001 covers 0x0000_0000 to 0x0001_FFFF.
- R4: A window whose valid bit is 0 never asserts its chip select.
- R5: With write-protect set, a write access (wr_i=1) inside the window asserts nothing. A read access inside the window still selects.
- R6: A set class-block bit stops its class from selecting the window. The classes are: CPU space (cpu_space_i=1), supervisor code, supervisor data, user code and user data (from super_i and code_i).
- R7: For a DMA access (dma_i=1) to a window whose DMA-class-enable bit is 0, the four supervisor/user code/data blocks are ignored. With that bit at 1 they apply. The CPU-space block applies in both cases.
- R8: When several windows qualify, only the lowest-numbered chip select asserts. cs_o is always one-hot or zero.
- R9: cs_o is loaded on each rising edge from the decode of the current inputs while as_i is 1. It clears on the edge after a cycle with as_i at 0. The decode uses the register contents from before a write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register byte offset for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| as_i | input | 1 | Address strobe |
| addr_i | input | 32 | Bus address |
| wr_i | input | 1 | Access is a write |
| super_i | input | 1 | Supervisor access |
| code_i | input | 1 | Code (instruction) access, else data |
| cpu_space_i | input | 1 | CPU-space / interrupt-acknowledge cycle |
| dma_i | input | 1 | Access from a DMA master |
| cs_o | output | 7 | Registered one-hot chip selects |

## Verification
A register write and a qualified access can fall in the same cycle. The decode must then use the old window settings, and the new ones take effect from the next access. The bench provokes this directly by enabling a window with a write while the strobe is high on an address in that window, and then repeating the access. It also mixes random register writes into a long run of random accesses. A behavioural model in the bench updates its register copy only after it has computed the expected outputs for the cycle. Every registered cs_o is compared against that model one clock later.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int NUM_CS    = 7;
  localparam int REG_AW    = 8;
  localparam int BASE_OFS  = 'h80;
  localparam int MASK_OFS  = 'h84;
  localparam int REG_STEP  = 12;

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] mask;
    logic        wp;
    logic        dma_cls;
    logic        blk_cpu;
    logic        blk_sc;
    logic        blk_sd;
    logic        blk_uc;
    logic        blk_ud;
    logic        valid;
  } win_cfg_t;

  typedef struct packed {
    logic wr;
    logic sup;
    logic code;
    logic cpu;
    logic dma;
  } acc_t;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
  import cs_pkg::*;
#(
  parameter int N  = NUM_CS,
  parameter int AW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output win_cfg_t      cfg_o [N]
);
  win_cfg_t cfg_q [N];

  for (genvar g = 0; g < N; g++) begin : g_win
    localparam logic [AW-1:0] BaseAddr = AW'(BASE_OFS + g * REG_STEP);
    localparam logic [AW-1:0] MaskAddr = AW'(MASK_OFS + g * REG_STEP);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= '0;
      end else if (we_i && addr_i == BaseAddr) begin
        cfg_q[g].base <= wdata_i[15:0];
      end else if (we_i && addr_i == MaskAddr) begin
        cfg_q[g].mask    <= wdata_i[31:16];
        cfg_q[g].wp      <= wdata_i[8];
        cfg_q[g].dma_cls <= wdata_i[6];
        cfg_q[g].blk_cpu <= wdata_i[5];
        cfg_q[g].blk_sc  <= wdata_i[4];
        cfg_q[g].blk_sd  <= wdata_i[3];
        cfg_q[g].blk_uc  <= wdata_i[2];
        cfg_q[g].blk_ud  <= wdata_i[1];
        cfg_q[g].valid   <= wdata_i[0];
      end
    end
    assign cfg_o[g] = cfg_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++) begin
      if (addr_i == AW'(BASE_OFS + i * REG_STEP))
        rdata_o = {16'h0, cfg_q[i].base};
      if (addr_i == AW'(MASK_OFS + i * REG_STEP))
        rdata_o = {cfg_q[i].mask, 7'h0, cfg_q[i].wp, 1'b0, cfg_q[i].dma_cls,
                   cfg_q[i].blk_cpu, cfg_q[i].blk_sc, cfg_q[i].blk_sd,
                   cfg_q[i].blk_uc, cfg_q[i].blk_ud, cfg_q[i].valid};
    end
  end

  // R2: mask write to window 0 lands in its field
  a_r2_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(MASK_OFS)) |=> cfg_q[0].mask == $past(wdata_i[31:16]));
endmodule

// File: rtl/cs_window.sv
module cs_window
  import cs_pkg::*;
(
  input  win_cfg_t    cfg_i,
  input  logic [15:0] addr_hi_i,
  input  acc_t        acc_i,
  output logic        hit_o
);
  logic addr_match, cls_block, wr_block;

  always_comb begin
    addr_match = ((addr_hi_i ^ cfg_i.base) & ~cfg_i.mask) == 16'h0;
    wr_block   = cfg_i.wp && acc_i.wr;
    if (acc_i.cpu)
      cls_block = cfg_i.blk_cpu;
    else if (acc_i.dma && !cfg_i.dma_cls)
      cls_block = 1'b0;
    else if (acc_i.sup)
      cls_block = acc_i.code ? cfg_i.blk_sc : cfg_i.blk_sd;
    else
      cls_block = acc_i.code ? cfg_i.blk_uc : cfg_i.blk_ud;
    hit_o = addr_match && cfg_i.valid && !wr_block && !cls_block;
  end

  always_comb begin
    a_r4_invalid_quiet: assert (cfg_i.valid || !hit_o);
    a_r5_wp_blocks:     assert (!(cfg_i.wp && acc_i.wr && hit_o));
  end
endmodule

// File: rtl/cs_select.sv
module cs_select #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    a_r8_lowest_wins: assert ((req_i == '0) || gnt_o[0] == req_i[0]);
  end
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
#(
  parameter int N  = NUM_CS,
  parameter int AW = REG_AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          as_i,
  input  logic [31:0]   addr_i,
  input  logic          wr_i,
  input  logic          super_i,
  input  logic          code_i,
  input  logic          cpu_space_i,
  input  logic          dma_i,
  output logic [N-1:0]  cs_o
);
  win_cfg_t     cfg [N];
  acc_t         acc;
  logic [N-1:0] hit, sel;
  logic [N-1:0] cs_q;

  assign acc = '{wr: wr_i, sup: super_i, code: code_i, cpu: cpu_space_i, dma: dma_i};

  cs_regfile #(.N(N), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg)
  );

  for (genvar g = 0; g < N; g++) begin : g_dec
    cs_window u_win (
      .cfg_i    (cfg[g]),
      .addr_hi_i(addr_i[31:16]),
      .acc_i    (acc),
      .hit_o    (hit[g])
    );
  end

  cs_select #(.N(N)) u_sel (.req_i(hit), .gnt_o(sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cs_q <= '0;
    else if (as_i) cs_q <= sel;
    else           cs_q <= '0;
  end
  assign cs_o = cs_q;

  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  a_r9_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> cs_o == '0);
  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_i |=> cs_o == $past(sel));
endmodule

// File: tb/cs_decoder_bench.sv
`timescale 1ns/1ps
module cs_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        as_s = 1'b0, wr_s = 1'b0, sup_s = 1'b0, code_s = 1'b0, cpu_s = 1'b0, dma_s = 1'b0;
  logic [31:0] addr_s = '0;
  logic [6:0]  cs;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] base_m [7];
  logic [31:0] mask_m [7];

  always #10 clk = ~clk;

  cs_decoder u_cs_decoder (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .as_i(as_s), .addr_i(addr_s),
    .wr_i(wr_s), .super_i(sup_s), .code_i(code_s), .cpu_space_i(cpu_s),
    .dma_i(dma_s), .cs_o(cs)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_dec();
    for (int i = 0; i < 7; i++) begin
      logic [31:0] m;
      logic blk;
      m = mask_m[i];
      if (((addr_s[31:16] ^ base_m[i]) & ~m[31:16]) != 16'h0) continue;
      if (!m[0]) continue;
      if (m[8] && wr_s) continue;
      if (cpu_s) blk = m[5];
      else if (dma_s && !m[6]) blk = 1'b0;
      else if (sup_s) blk = code_s ? m[4] : m[3];
      else blk = code_s ? m[2] : m[1];
      if (blk) continue;
      return 7'(1 << i);
    end
    return 7'h0;
  endfunction

  function automatic logic [31:0] ref_read(logic [7:0] a);
    for (int i = 0; i < 7; i++) begin
      if (a == 8'(8'h80 + 12 * i)) return {16'h0, base_m[i]};
      if (a == 8'(8'h84 + 12 * i)) return mask_m[i];
    end
    return 32'h0;
  endfunction

  task automatic model_write();
    if (!reg_we) return;
    for (int i = 0; i < 7; i++) begin
      if (reg_addr == 8'(8'h80 + 12 * i)) base_m[i] = reg_wdata[15:0];
      if (reg_addr == 8'(8'h84 + 12 * i)) mask_m[i] = reg_wdata & 32'hFFFF_017F;
    end
  endtask

  // one clock: expectation from current inputs and pre-write model state
  task automatic cyc(string tag);
    logic [6:0] exp;
    exp = as_s ? ref_dec() : 7'h0;
    @(posedge clk);
    model_write();
    @(negedge clk);
    check(tag, 32'(cs), 32'(exp));
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc("R2");
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, string tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, ref_read(a));
  endtask

  task automatic acc(logic [31:0] a, logic w, logic s, logic c, logic cp, logic d, string tag);
    as_s = 1'b1; addr_s = a; wr_s = w; sup_s = s; code_s = c; cpu_s = cp; dma_s = d;
    cyc(tag);
  endtask

  task automatic acc_exp(logic [31:0] a, logic w, logic s, logic c, logic cp, logic d,
                         logic [6:0] exp, string tag);
    acc(a, w, s, c, cp, d, tag);
    check(tag, 32'(cs), 32'(exp));
  endtask

  task automatic idle(string tag);
    as_s = 1'b0;
    cyc(tag);
  endtask

  initial begin
    #(20.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) begin base_m[i] = '0; mask_m[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1", 32'(cs), 32'h0);
    rd_chk(8'h80, "R1"); rd_chk(8'hCC, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      rd_chk(8'(8'h80 + 12 * i), "R1");
      rd_chk(8'(8'h84 + 12 * i), "R1");
    end
    check("R1", 32'(cs), 32'h0);
    acc_exp(32'h0000_0000, 0, 1, 0, 0, 0, 7'h00, "R1");
    idle("R9");

    // R2 map and reserved bits
    wr_reg(8'h84, 32'hFFFF_FFFF);
    rd_chk(8'h84, "R2"); check("R2", reg_rdata, 32'hFFFF_017F);
    wr_reg(8'h80, 32'hABCD_1234);
    rd_chk(8'h80, "R2"); check("R2", reg_rdata, 32'h0000_1234);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, "R2"); check("R2", reg_rdata, 32'h0);
    rd_chk(8'h88, "R2");
    wr_reg(8'hCC, 32'h0003_0001);
    rd_chk(8'hCC, "R2"); check("R2", reg_rdata, 32'h0003_0001);
    wr_reg(8'hC8, 32'h0000_0040);
    rd_chk(8'hC8, "R2");
    wr_reg(8'h84, 32'h0);
    wr_reg(8'hCC, 32'h0);

    // R3 window match: base 0, mask 0x0001 -> 0..0x1_FFFF
    wr_reg(8'h80, 32'h0);
    wr_reg(8'h84, 32'h0001_0001);
    acc_exp(32'h0001_FFFC, 0, 1, 0, 0, 0, 7'h01, "R3");
    acc_exp(32'h0000_0000, 0, 0, 1, 0, 0, 7'h01, "R3");
    acc_exp(32'h0002_0000, 0, 1, 0, 0, 0, 7'h00, "R3");
    wr_reg(8'h8C, 32'h0000_0120);
    wr_reg(8'h90, 32'h000F_0001);
    acc_exp(32'h012F_8000, 0, 1, 0, 0, 0, 7'h02, "R3");
    acc_exp(32'h0130_0000, 0, 1, 0, 0, 0, 7'h00, "R3");

    // R4 valid bit
    wr_reg(8'h90, 32'h000F_0000);
    acc_exp(32'h0125_0000, 0, 1, 0, 0, 0, 7'h00, "R4");

    // R5 write protect
    wr_reg(8'h84, 32'h0001_0101);
    acc_exp(32'h0000_1000, 1, 1, 0, 0, 0, 7'h00, "R5");
    acc_exp(32'h0000_1000, 0, 1, 0, 0, 0, 7'h01, "R5");

    // R6 class blocks: sc(bit4)
    wr_reg(8'h84, 32'h0001_0011);
    acc_exp(32'h0000_1000, 0, 1, 1, 0, 0, 7'h00, "R6");
    acc_exp(32'h0000_1000, 0, 1, 0, 0, 0, 7'h01, "R6");
    wr_reg(8'h84, 32'h0001_0003);
    acc_exp(32'h0000_1000, 0, 0, 0, 0, 0, 7'h00, "R6");
    acc_exp(32'h0000_1000, 0, 0, 1, 0, 0, 7'h01, "R6");
    wr_reg(8'h84, 32'h0001_0021);
    acc_exp(32'h0000_1000, 0, 1, 0, 1, 0, 7'h00, "R6");

    // R7 DMA handling
    wr_reg(8'h84, 32'h0001_003F);
    acc_exp(32'h0000_1000, 0, 1, 1, 0, 1, 7'h01, "R7");
    acc_exp(32'h0000_1000, 0, 1, 1, 0, 0, 7'h00, "R7");
    acc_exp(32'h0000_1000, 0, 1, 0, 1, 1, 7'h00, "R7");
    wr_reg(8'h84, 32'h0001_007F);
    acc_exp(32'h0000_1000, 0, 0, 0, 0, 1, 7'h00, "R7");

    // R8 overlap: windows 1 and 3 cover same range
    wr_reg(8'h84, 32'h0);
    wr_reg(8'h8C, 32'h0000_0400);
    wr_reg(8'h90, 32'h00FF_0001);
    wr_reg(8'hA4, 32'h0000_0400);
    wr_reg(8'hA8, 32'h00FF_0001);
    acc_exp(32'h0410_0000, 0, 1, 0, 0, 0, 7'h02, "R8");
    wr_reg(8'h90, 32'h00FF_0000);
    acc_exp(32'h0410_0000, 0, 1, 0, 0, 0, 7'h08, "R8");

    // R9 strobe timing and same-cycle write
    idle("R9");
    check("R9", 32'(cs), 32'h0);
    as_s = 1'b1; addr_s = 32'h0410_0000; sup_s = 1'b1;
    reg_we = 1'b1; reg_addr = 8'h90; reg_wdata = 32'h00FF_0001;
    cyc("R9");
    reg_we = 1'b0;
    check("R9", 32'(cs), 32'h08);
    acc_exp(32'h0410_0000, 0, 1, 0, 0, 0, 7'h02, "R9");
    idle("R9");

    // random mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] pick [4];
      pick[0] = 16'h0000; pick[1] = 16'h0010; pick[2] = 16'h0400; pick[3] = 16'h1000;
      reg_we = ($urandom_range(0, 7) == 0);
      reg_addr = 8'(8'h80 + 12 * $urandom_range(0, 6) + 4 * $urandom_range(0, 1));
      reg_wdata = {16'($urandom_range(0, 31)), 16'($urandom)};
      if (!reg_addr[2]) reg_wdata[15:0] = pick[$urandom_range(0, 3)];
      as_s = ($urandom_range(0, 4) != 0);
      addr_s = {pick[$urandom_range(0, 3)] ^ 16'($urandom_range(0, 31)), 16'($urandom)};
      wr_s = 1'($urandom); sup_s = 1'($urandom); code_s = 1'($urandom);
      cpu_s = ($urandom_range(0, 5) == 0); dma_s = 1'($urandom);
      cyc("R3");
      if (n % 50 == 0) rd_chk(reg_addr, "R2");
    end
    reg_we = 1'b0;
    idle("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule